// File: doc/BRIEF.md
# Idle-Counting Sideband Clock Gate Controller

This block watches a sideband endpoint for activity and decides when its clock may be stopped. While the endpoint is quiet, a counter tallies consecutive idle clocks. When the tally reaches a programmable limit, the state machine enters its idle state. If clock masking is also allowed at that point, the block drops the enable it feeds to an external clock gate cell. Any activity returns the machine to its active state, and the enable comes back in that same cycle.

A single 32-bit configuration word controls the block, and the block also reads it back. The word holds four controls:
- an 8-bit idle count limit;
- a gating-allow bit, which lets the machine leave the active state at all;
- a masking-defeature bit, which lets the machine go idle but keeps the clock running;
- a master disable for the whole functional gating machine.

The defeature control is separate from the allow control. This means the idle handshake can complete while the clock stays up, which is useful when debugging gating problems.

Top module: `sb_idle_gate`

## Requirements
- R1: After a synchronous reset, the configuration word reads 0x00000510 and the state output is ACTIVE. The state encodings are ACTIVE=0, IDLE_PENDING=1 and IDLE=2. After reset, clk_en is 1. The word's fields are: idle limit in bits 7:0, gating-allow in bit 8, masking-defeature in bit 9, master disable in bit 10.
- R2: Bits 31:11 of the configuration word always read 0, whatever is written to them. A write updates bits 10:0 at the next clock edge.
- R3: Gating must be running, which means allow=1 and disable=0. In that case, after k consecutive idle edges (activity low), the state is IDLE_PENDING while 1 ≤ k < limit and IDLE once k ≥ limit.
- R4: An idle limit of 0 behaves exactly like a limit of 1: a single idle edge reaches IDLE.
- R5: activity high at a clock edge puts the state back to ACTIVE after that edge and restarts the idle count from zero.
- R6: While activity is high, clk_en is 1 in the same cycle, with no register delay.
- R7: clk_en is 0 only when all of these hold: the state is IDLE, allow=1, defeature=0, disable=0, and activity=0.
- R8: With defeature=1, the state machine still reaches IDLE on schedule, but clk_en stays 1.
- R9: With allow=0, the state is ACTIVE after every clock edge and no idle cycles are counted.
- R10: With the master disable=1, the state is ACTIVE after every clock edge and clk_en stays 1, whatever the other bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (ungated side) |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration write data |
| activity | input | 1 | Endpoint busy indication |
| cfg_rdata | output | 32 | Configuration word readback |
| gate_state | output | 2 | Current state: 0 ACTIVE, 1 IDLE_PENDING, 2 IDLE |
| clk_en | output | 1 | Enable for the external clock gate cell |

## Verification
The configuration readback and the state both change one edge after the input that causes them. A write is visible on cfg_rdata after the following edge, and an idle or active sample moves gate_state at that same edge. clk_en is different: it answers activity combinationally in the same cycle, but it answers state and configuration only one edge later. The bench drives its inputs just after the falling edge and checks every output one time unit later. Its behavioural model advances on each rising edge using the inputs that were present there. As a result, registered results are compared one edge after their cause, and the combinational activity path is compared within the same cycle.

// File: rtl/sb_idle_gate_pkg.sv
package sb_idle_gate_pkg;

    localparam int REG_W  = 32;
    localparam int LIM_W  = 8;
    localparam int USED_W = LIM_W + 3;

    typedef enum logic [1:0] {
        ST_ACTIVE  = 2'd0,
        ST_PENDING = 2'd1,
        ST_IDLE    = 2'd2
    } gate_st_e;

    typedef struct packed {
        logic             fgate_off;
        logic             mask_defeat;
        logic             gate_allow;
        logic [LIM_W-1:0] idle_lim;
    } gate_cfg_t;

    function automatic gate_cfg_t cfg_reset(input logic [LIM_W-1:0] lim);
        gate_cfg_t c;
        c.fgate_off   = 1'b1;
        c.mask_defeat = 1'b0;
        c.gate_allow  = 1'b1;
        c.idle_lim    = lim;
        return c;
    endfunction

    function automatic logic [LIM_W-1:0] eff_limit(input logic [LIM_W-1:0] lim);
        return (lim == '0) ? LIM_W'(1) : lim;
    endfunction

    function automatic logic gating_runs(input gate_cfg_t c);
        return c.gate_allow && !c.fgate_off;
    endfunction

endpackage

// File: rtl/sb_cfg_reg.sv
module sb_cfg_reg
    import sb_idle_gate_pkg::*;
#(
    parameter logic [LIM_W-1:0] RST_LIM = 8'h10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output gate_cfg_t        cfg,
    output logic [REG_W-1:0] rdata
);
    localparam int PAD_W = REG_W - USED_W;

    gate_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= cfg_reset(RST_LIM);
        else if (we)
            cfg_q <= gate_cfg_t'(wdata[USED_W-1:0]);
    end

    assign cfg   = cfg_q;
    assign rdata = {{PAD_W{1'b0}}, cfg_q};

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> rdata[USED_W-1:0] == $past(wdata[USED_W-1:0]));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(rdata));
endmodule

// File: rtl/sb_idle_fsm.sv
module sb_idle_fsm
    import sb_idle_gate_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  gate_cfg_t cfg,
    input  logic      activity,
    output gate_st_e  state
);
    localparam logic [LIM_W-1:0] CNT_MAX = '1;

    gate_st_e         st_q, st_n;
    logic [LIM_W-1:0] cnt_q, cnt_n, lim;
    logic             run;

    assign lim = eff_limit(cfg.idle_lim);
    assign run = gating_runs(cfg);

    always_comb begin
        st_n  = ST_ACTIVE;
        cnt_n = '0;
        if (run && !activity) begin
            cnt_n = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
            st_n  = (cnt_n >= lim) ? ST_IDLE : ST_PENDING;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_ACTIVE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

    assign state = st_q;

    // R5
    act_return_chk: assert property (@(posedge clk) disable iff (rst)
        activity |=> state == ST_ACTIVE);

    // R9
    no_allow_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg.gate_allow |=> state == ST_ACTIVE);

    // R10
    fgate_off_chk: assert property (@(posedge clk) disable iff (rst)
        cfg.fgate_off |=> state == ST_ACTIVE);

    // R3
    no_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACTIVE && lim > 1) |=> state != ST_IDLE);

    // R3
    legal_state_chk: assert property (@(posedge clk) disable iff (rst)
        state != 2'd3);
endmodule

// File: rtl/sb_clk_mask.sv
module sb_clk_mask
    import sb_idle_gate_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  gate_cfg_t cfg,
    input  gate_st_e  state,
    input  logic      activity,
    output logic      clk_en
);
    logic mask_ok;

    assign mask_ok = gating_runs(cfg) && !cfg.mask_defeat;
    assign clk_en  = activity || !(state == ST_IDLE && mask_ok);

    // R6
    act_clken_chk: assert property (@(posedge clk) disable iff (rst)
        activity |-> clk_en);

    // R8
    defeat_chk: assert property (@(posedge clk) disable iff (rst)
        cfg.mask_defeat |-> clk_en);

    // R7
    off_only_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !clk_en |-> state == ST_IDLE);
endmodule

// File: rtl/sb_idle_gate.sv
module sb_idle_gate
    import sb_idle_gate_pkg::*;
#(
    parameter logic [7:0] RST_LIM = 8'h10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    input  logic        activity,
    output logic [31:0] cfg_rdata,
    output logic [1:0]  gate_state,
    output logic        clk_en
);
    gate_cfg_t cfg;
    gate_st_e  st;

    sb_cfg_reg #(.RST_LIM(RST_LIM)) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
        .cfg(cfg), .rdata(cfg_rdata)
    );

    sb_idle_fsm u_fsm (
        .clk(clk), .rst(rst), .cfg(cfg), .activity(activity), .state(st)
    );

    sb_clk_mask u_mask (
        .clk(clk), .rst(rst), .cfg(cfg), .state(st),
        .activity(activity), .clk_en(clk_en)
    );

    assign gate_state = st;

    // R1
    rst_state_chk: assert property (@(posedge clk)
        rst |=> (gate_state == 2'd0 && cfg_rdata == 32'h510));
endmodule

// File: tb/test_sb_idle_gate.sv
module test_sb_idle_gate;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        activity = 1'b0;
    logic [31:0] cfg_rdata;
    logic [1:0]  gate_state;
    logic        clk_en;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    string req = "R1";

    // behavioural reference
    int m_cfg = 'h510;
    int m_cnt = 0;
    int m_st  = 0;

    always #4 clk = ~clk;

    sb_idle_gate i_sb_idle_gate (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .activity(activity), .cfg_rdata(cfg_rdata),
        .gate_state(gate_state), .clk_en(clk_en)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            m_cfg = 'h510; m_cnt = 0; m_st = 0;
        end else begin
            int lim;
            bit runs;
            lim  = m_cfg & 'hFF;
            if (lim == 0) lim = 1;
            runs = m_cfg[8] && !m_cfg[10];
            if (!runs || activity) begin
                m_cnt = 0; m_st = 0;
            end else begin
                if (m_cnt < 255) m_cnt = m_cnt + 1;
                m_st = (m_cnt >= lim) ? 2 : 1;
            end
            if (cfg_we) m_cfg = cfg_wdata & 'h7FF;
        end
    end

    function automatic bit exp_clk_en();
        return activity || !(m_st == 2 && m_cfg[8] && !m_cfg[9] && !m_cfg[10]);
    endfunction

    task automatic compare();
        n_cmp++;
        if (cfg_rdata !== 32'(m_cfg)) begin
            n_bad++;
            $display("FAIL %s cfg_rdata actual %h expected %h", req, cfg_rdata, m_cfg);
        end
        n_cmp++;
        if (gate_state !== 2'(m_st)) begin
            n_bad++;
            $display("FAIL %s gate_state actual %0d expected %0d", req, gate_state, m_st);
        end
        n_cmp++;
        if (clk_en !== exp_clk_en()) begin
            n_bad++;
            $display("FAIL %s clk_en actual %b expected %b", req, clk_en, exp_clk_en());
        end
    endtask

    task automatic step(input bit act, input bit we = 0, input logic [31:0] wd = '0);
        @(negedge clk);
        activity  = act;
        cfg_we    = we;
        cfg_wdata = wd;
        #1 compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        while (cyc < 100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        req = "R1"; step(1'b0);          // reset value and state
        // default: master disable set, stays ACTIVE
        req = "R10"; idle(20);
        // R2: reserved bits written as ones read back as zero
        req = "R2"; step(1'b0, 1'b1, 32'hFFFF_F105);
        idle(1);
        // R3: limit 5, gating runs
        req = "R3"; idle(8);
        // R5 / R6: activity returns to ACTIVE, enable same cycle
        req = "R6"; step(1'b1);
        req = "R5"; idle(3); step(1'b1); idle(7);
        // R4: limit zero
        req = "R4"; step(1'b1, 1'b1, 32'h0000_0100); idle(3);
        // R8: defeature
        req = "R8"; step(1'b1, 1'b1, 32'h0000_0303); idle(6);
        // R9: allow cleared
        req = "R9"; step(1'b0, 1'b1, 32'h0000_0003); idle(10);
        // R10: master disable with allow
        req = "R10"; step(1'b0, 1'b1, 32'h0000_0501); idle(10);
        // R7: mixed activity, limit 3 then limit 1
        req = "R7"; step(1'b0, 1'b1, 32'h0000_0103);
        for (int i = 0; i < 300; i++) step(1'($urandom_range(0, 3) == 0));
        step(1'b0, 1'b1, 32'h0000_0101);
        for (int i = 0; i < 300; i++) step(1'($urandom_range(0, 2) == 0));
        // R1: reset again mid-idle
        req = "R1"; idle(4);
        @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
        #1 compare();
        finish_run();
    end
endmodule